// File: doc/BRIEF.md
# Programmable Clamp Pulse Generator

This block produces one clamp-enable pulse per video line for the pedestal clamp of a video front end. Each line is marked by a one-cycle strobe from an upstream sync detector. From that strobe the block counts pixel clocks, raises its clamp output after a programmable delay, and holds it for a programmable number of clocks.

Delay and width are set through one 8-bit control byte, written and read over a simple port. Two 3-bit codes in that byte select values from fixed, unevenly spaced tables of clock counts. A 2-bit slice-level field shares the byte; it is stored and read back but does not change the pulse timing. With a pixel clock of about 37 ns, the reset setting places the pulse about 5.5 µs after the sync reference. The block only counts clocks and asserts the pulse window. Sync detection and the analog clamp lie outside it.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset the control byte reads 0x1C, and clamp_o stays low until the first strobe.
- R2: A write stores wr_data_i unchanged, and the byte can be read back on rd_data_o in the cycle after the write. This holds for any value, including the slice code 2'b10 in bits [7:6]. Without a write the byte is unchanged.
- R3: Bits [2:0] select the start delay S. Codes 0 through 7 map to 118, 126, 132, 140, 148, 156, 164 and 172 clocks. If sync_i is high at clock edge E0, clamp_o first goes high in the cycle that follows edge E(S).
- R4: Bits [5:3] select the pulse width W. Codes 0 through 7 map to 16, 24, 28, 32, 40, 44, 48 and 52 clocks. clamp_o stays high for exactly W consecutive cycles.
- R5: With the reset byte (start code 3'b100, width code 3'b011), the pulse covers the cycles after edges E148 through E179.
- R6: A strobe that arrives while a pulse is pending or active forces clamp_o low in the following cycle. Timing then restarts from that strobe.
- R7: The timing codes are sampled only at a strobe. A write during a line does not change that line's pulse. A write in the same cycle as a strobe applies from the next strobe.
- R8: Once a pulse has ended, clamp_o stays low until another strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | One-cycle line reference strobe |
| wr_en_i | input | 1 | Control byte write enable |
| wr_data_i | input | 8 | Control byte write data |
| rd_data_o | output | 8 | Stored control byte |
| clamp_o | output | 1 | Clamp enable pulse |

## Verification
The bench builds the block with its default counter width of 8 bits. This width holds the longest window, 172 + 52 = 224 clocks, so every start code and every width code can be swept in full, and the last cycle of the longest pulse is observed. The directed lines also cover a strobe during a pending pulse, a strobe during an active pulse, a write in the middle of a pulse, and a write that coincides with a strobe. Each line is compared cycle by cycle against a window computed from the two tables.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

  localparam int unsigned CFG_W  = 8;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned LUT_W  = 8;

  typedef struct packed {
    logic [1:0]        slice;
    logic [CODE_W-1:0] width;
    logic [CODE_W-1:0] start;
  } clamp_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST = 8'h1C;

  function automatic logic [LUT_W-1:0] start_clks(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 8'd118;
      3'd1:    return 8'd126;
      3'd2:    return 8'd132;
      3'd3:    return 8'd140;
      3'd4:    return 8'd148;
      3'd5:    return 8'd156;
      3'd6:    return 8'd164;
      default: return 8'd172;
    endcase
  endfunction

  function automatic logic [LUT_W-1:0] width_clks(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    return 8'd16;
      3'd1:    return 8'd24;
      3'd2:    return 8'd28;
      3'd3:    return 8'd32;
      3'd4:    return 8'd40;
      3'd5:    return 8'd44;
      3'd6:    return 8'd48;
      default: return 8'd52;
    endcase
  endfunction

endpackage

// File: rtl/clamp_cfg_reg.sv
module clamp_cfg_reg
  import clamp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] rd_data_o,
  output clamp_cfg_t       cfg_o
);

  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= CFG_RST;
    else if (wr_en_i) cfg_q <= wr_data_i;
  end

  assign rd_data_o = cfg_q;
  assign cfg_o     = clamp_cfg_t'(cfg_q);

  assert_wr_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  assert_cfg_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

endmodule

// File: rtl/clamp_lut.sv
module clamp_lut
  import clamp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  clamp_cfg_t       cfg_i,
  output logic [CNT_W-1:0] start_cnt_o,
  output logic [CNT_W-1:0] end_cnt_o
);

  logic [CNT_W-1:0] width_cnt;

  always_comb begin
    start_cnt_o = CNT_W'(start_clks(cfg_i.start));
    width_cnt   = CNT_W'(width_clks(cfg_i.width));
    end_cnt_o   = start_cnt_o + width_cnt;
  end

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic [CNT_W-1:0] end_cnt_i,
  output logic             clamp_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] end_q;

  // window parameters are latched at the strobe so writes wait for the next line
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
    end else if (sync_i) begin
      run_q   <= 1'b1;
      cnt_q   <= '0;
      start_q <= start_cnt_i;
      end_q   <= end_cnt_i;
    end else if (run_q) begin
      if (cnt_q == end_q - ONE) run_q <= 1'b0;
      else                      cnt_q <= cnt_q + ONE;
    end
  end

  assign clamp_o = run_q && (cnt_q >= start_q);

  // checker-only run length of the current pulse
  logic [CNT_W-1:0] hi_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_len_q <= '0;
    else if (clamp_o) hi_len_q <= hi_len_q + ONE;
    else              hi_len_q <= '0;
  end

  assert_rise_at_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_o) |-> cnt_q == start_q);

  assert_width_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clamp_o) && !$past(sync_i)) |-> $past(hi_len_q) == end_q - start_q - ONE);

  assert_strobe_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !clamp_o);

  assert_cfg_latched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> ($stable(start_q) && $stable(end_q)));

  assert_no_retrigger_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clamp_o && !run_q && !sync_i) |=> !clamp_o);

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       clamp_o
);

  clamp_cfg_t       cfg;
  logic [CNT_W-1:0] start_cnt;
  logic [CNT_W-1:0] end_cnt;

  clamp_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .cfg_o     (cfg)
  );

  clamp_lut #(.CNT_W(CNT_W)) u_lut (
    .cfg_i       (cfg),
    .start_cnt_o (start_cnt),
    .end_cnt_o   (end_cnt)
  );

  clamp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .start_cnt_i (start_cnt),
    .end_cnt_i   (end_cnt),
    .clamp_o     (clamp_o)
  );

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !clamp_o);

endmodule

// File: tb/tb_clamp_pulse_gen.sv
`timescale 1ns/1ps
module tb_clamp_pulse_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       clamp;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clamp_pulse_gen dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sync_i    (sync),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .clamp_o   (clamp)
  );

  function automatic int exp_start(input int code);
    int t[8] = '{118, 126, 132, 140, 148, 156, 164, 172};
    return t[code];
  endfunction

  function automatic int exp_width(input int code);
    int t[8] = '{16, 24, 28, 32, 40, 44, 48, 52};
    return t[code];
  endfunction

  // convention: every task starts and ends on a falling edge (a sample point)
  task automatic strobe(input logic do_wr, input logic [7:0] v);
    sync    = 1'b1;
    wr_en   = do_wr;
    wr_data = v;
    @(negedge clk);
    sync  = 1'b0;
    wr_en = 1'b0;
  endtask

  // sample point i lies after the i-th rising edge following the strobe edge
  task automatic check_span(input int st, input int w, input int i0, input int i1,
                            input int wr_at, input logic [7:0] wr_val, input string tag);
    int   bad_i = -1;
    logic bad_v = 1'b0;
    logic exp_v;
    for (int i = i0; i < i1; i++) begin
      exp_v = (i >= st) && (i < st + w);
      if (clamp !== exp_v && bad_i < 0) begin
        bad_i = i;
        bad_v = clamp;
      end
      wr_en   = (i == wr_at);
      wr_data = wr_val;
      @(negedge clk);
    end
    wr_en = 1'b0;
    checks++;
    if (bad_i >= 0) begin
      errors++;
      $display("FAIL %s clamp at cycle %0d actual %0b expected %0b", tag, bad_i, bad_v, ~bad_v);
    end
  endtask

  task automatic write_byte(input logic [7:0] v, input string tag);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    checks++;
    if (rd_data !== v) begin
      errors++;
      $display("FAIL %s rd_data actual %02h expected %02h", tag, rd_data, v);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (rd_data !== 8'h1C) begin
      errors++;
      $display("FAIL R1 reset rd_data actual %02h expected 1c", rd_data);
    end
    check_span(10000, 0, 0, 300, -1, 8'h00, "R1 idle after reset");
  endtask

  task automatic t_default;
    strobe(1'b0, 8'h00);
    check_span(148, 32, 0, 300, -1, 8'h00, "R5 default window");
    check_span(10000, 0, 300, 700, -1, 8'h00, "R8 no retrigger");
  endtask

  task automatic t_start_sweep;
    for (int c = 0; c < 8; c++) begin
      write_byte({2'b00, 3'b011, 3'(c)}, "R2 start code write");
      strobe(1'b0, 8'h00);
      check_span(exp_start(c), 32, 0, 260, -1, 8'h00, $sformatf("R3 start code %0d", c));
    end
  endtask

  task automatic t_width_sweep;
    for (int c = 0; c < 8; c++) begin
      write_byte({2'b00, 3'(c), 3'b000}, "R2 width code write");
      strobe(1'b0, 8'h00);
      check_span(118, exp_width(c), 0, 200, -1, 8'h00, $sformatf("R4 width code %0d", c));
    end
    write_byte({2'b00, 3'b111, 3'b111}, "R2 longest window write");
    strobe(1'b0, 8'h00);
    check_span(172, 52, 0, 260, -1, 8'h00, "R4 longest window");
  endtask

  task automatic t_retrigger;
    write_byte(8'h1C, "R2 restore default");
    strobe(1'b0, 8'h00);
    check_span(148, 32, 0, 100, -1, 8'h00, "R6 pending before strobe");
    strobe(1'b0, 8'h00);
    check_span(148, 32, 0, 160, -1, 8'h00, "R6 restart from pending");
    strobe(1'b0, 8'h00);
    check_span(148, 32, 0, 300, -1, 8'h00, "R6 restart from active");
  endtask

  task automatic t_midline_write;
    strobe(1'b0, 8'h00);
    check_span(148, 32, 0, 300, 155, {2'b00, 3'b111, 3'b000}, "R7 write during pulse");
    strobe(1'b0, 8'h00);
    check_span(118, 52, 0, 260, -1, 8'h00, "R7 write applied next line");
  endtask

  task automatic t_same_cycle_write;
    strobe(1'b1, {2'b00, 3'b000, 3'b111});
    check_span(118, 52, 0, 260, -1, 8'h00, "R7 write with strobe uses old");
    strobe(1'b0, 8'h00);
    check_span(172, 16, 0, 260, -1, 8'h00, "R7 write with strobe next line");
  endtask

  task automatic t_readback;
    write_byte(8'hAA, "R2 slice code 10 readback");
    check_span(10000, 0, 0, 5, -1, 8'h00, "R2 hold idle");
    checks++;
    if (rd_data !== 8'hAA) begin
      errors++;
      $display("FAIL R2 hold rd_data actual %02h expected aa", rd_data);
    end
    write_byte(8'hFF, "R2 all ones readback");
    write_byte(8'h00, "R2 all zeros readback");
  endtask

  initial begin
    rst_n   = 1'b0;
    sync    = 1'b0;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_default();
    t_start_sweep();
    t_width_sweep();
    t_retrigger();
    t_midline_write();
    t_same_cycle_write();
    t_readback();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule